// File: doc/BRIEF.md
# Addressing-Mode Operand Executor

This block carries out the memory-touching part of three instructions of a small 8-bit accumulator machine: MOV, ADD and MVI. A decoder hands it an opcode class, an addressing-mode code, a space-select bit and up to two operand bytes, then pulses `start`. The block then issues its own read and write cycles on a single-port byte memory. That memory has a one-cycle read latency and two spaces, RAM and register space. It holds the accumulator and the index register.

Five addressing forms are handled:

- an immediate byte stored to a direct address, or to an address indexed by X;
- the same two targets used for a read-add-write;
- a copy from one RAM byte to another;
- a load through a pointer kept in RAM, with the pointer bumped afterwards;
- a store through such a pointer, with the pointer bumped afterwards.

Any opcode and mode pairing outside these forms is refused. The block reports it as illegal and touches no memory. All address arithmetic wraps at 256. A one-cycle `done` follows the last write of each instruction.

Top module: `amode_exec`

## Requirements
- R1: After reset, `acc`, `xreg`, `carry` and `zero` are 0, and `busy`, `done`, `illegal` and `mem_req` are low.
- R2: MOV (op=0) with mode 0 (target opnd1) or mode 1 (target opnd1+X) makes exactly one write cycle. The write puts opnd2 at the target in the space that `reg_space` selects (1 = register space). `done` rises two cycles after the start edge.
- R3: ADD (op=1) with mode 0 or 1 reads the target in the selected space. On the next cycle it writes the read byte plus opnd2 to the same address. `done` rises three cycles after the start edge.
- R4: ADD sets `carry` to the carry out of bit 7 of the sum, and sets `zero` when the 8-bit sum is 0.
- R5: MOV and MVI leave `carry` and `zero` unchanged.
- R6: MOV with mode 2 reads the RAM byte at opnd2 and writes it to the RAM byte at opnd1. `done` rises three cycles after the start edge.
- R7: MVI (op=2) with mode 3 reads pointer P from RAM[opnd1] and loads RAM[P] into `acc`. It then writes P+1 to RAM[opnd1]. `done` rises four cycles after the start edge.
- R8: MVI with mode 4 reads pointer P from RAM[opnd1] and writes `acc` to RAM[P]. It then writes P+1 to RAM[opnd1]. `done` rises four cycles after the start edge.
- R9: These pairings are illegal: op 3; mode 5 to 7; MVI outside modes 3 and 4; MOV or ADD in mode 3 or 4; ADD in mode 2; MOV in mode 2 with `reg_space`=1. An illegal pairing makes no memory request. It raises `done` and `illegal` together two cycles after the start edge.
- R10: X plus opnd1 and pointer plus one both wrap modulo 256.
- R11: `start` is ignored while `busy` is high.
- R12: `done` is high for exactly one cycle per instruction. `illegal` is only high alongside `done`.
- R13: `a_we`/`a_wdata` and `x_we`/`x_wdata` load `acc` and `xreg` on an idle cycle, and are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (idle only) |
| op | input | 2 | 0 MOV, 1 ADD, 2 MVI, 3 reserved |
| mode | input | 3 | 0 direct+imm, 1 indexed+imm, 2 direct-direct, 3 pointer load, 4 pointer store |
| reg_space | input | 1 | Space for modes 0/1: 1 register space, 0 RAM |
| opnd1 | input | 8 | First operand byte |
| opnd2 | input | 8 | Second operand byte |
| a_we | input | 1 | Load accumulator when idle |
| a_wdata | input | 8 | Accumulator load value |
| x_we | input | 1 | Load index register when idle |
| x_wdata | input | 8 | Index load value |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_reg | output | 1 | 1 register space, 0 RAM |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion was a refused pairing |
| acc | output | 8 | Accumulator |
| xreg | output | 8 | Index register |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |

## Verification
The assertions assume that `mem_rdata` carries the byte from the requested address in the cycle after a read request. They also assume that the memory lets a write follow a read at once.

The bench memory model behaves in exactly that way. It answers every read on the next edge, from the space that `mem_reg` selects.

Stimulus is driven on falling edges. Operand and mode inputs stay steady from the cycle `start` is raised until the block goes busy. Load strobes are raised only while the block is idle, except in the scenario that checks they are ignored while busy.

// File: rtl/amode_pkg.sv
package amode_pkg;
    localparam int unsigned DW = 8;

    localparam logic [1:0] OP_MOV = 2'd0;
    localparam logic [1:0] OP_ADD = 2'd1;
    localparam logic [1:0] OP_MVI = 2'd2;

    localparam logic [2:0] AM_DIMM = 3'd0;
    localparam logic [2:0] AM_XIMM = 3'd1;
    localparam logic [2:0] AM_DD   = 3'd2;
    localparam logic [2:0] AM_ILD  = 3'd3;
    localparam logic [2:0] AM_IST  = 3'd4;

    typedef enum logic [2:0] {S_IDLE, S_RDA, S_MID, S_LAST, S_ILL} st_e;

    typedef struct packed {
        st_e           st;
        logic [1:0]    op;
        logic [2:0]    md;
        logic          sp;
        logic [DW-1:0] o1;
        logic [DW-1:0] o2;
        logic [DW-1:0] ptr;
        logic [DW-1:0] a;
        logic [DW-1:0] x;
        logic          cf;
        logic          zf;
        logic          done;
        logic          ill;
    } ctx_t;

    function automatic logic pair_ok(logic [1:0] op, logic [2:0] md, logic sp);
        case (md)
            AM_DIMM, AM_XIMM: pair_ok = (op == OP_MOV) || (op == OP_ADD);
            AM_DD:            pair_ok = (op == OP_MOV) && !sp;
            AM_ILD, AM_IST:   pair_ok = (op == OP_MVI);
            default:          pair_ok = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/amode_agen.sv
module amode_agen #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] idx,
    input  logic         idx_en,
    input  logic [W-1:0] ptr,
    output logic [W-1:0] tgt,
    output logic [W-1:0] ptr_nxt
);
    always_comb begin
        tgt     = base + (idx_en ? idx : '0);
        ptr_nxt = ptr + W'(1);
    end
endmodule

// File: rtl/amode_alu.sv
module amode_alu #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         zf
);
    always_comb begin
        {cout, sum} = {1'b0, lhs} + {1'b0, rhs};
        zf          = (sum == '0);
    end
endmodule

// File: rtl/amode_exec.sv
module amode_exec
    import amode_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [2:0]    mode,
    input  logic          reg_space,
    input  logic [DW-1:0] opnd1,
    input  logic [DW-1:0] opnd2,
    input  logic          a_we,
    input  logic [DW-1:0] a_wdata,
    input  logic          x_we,
    input  logic [DW-1:0] x_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_reg,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] xreg,
    output logic          carry,
    output logic          zero
);
    ctx_t c_q, c_d;

    logic [DW-1:0] tgt, ptr_nxt, sum;
    logic          add_c, add_z, imm_md;

    assign imm_md = (c_q.md == AM_DIMM) || (c_q.md == AM_XIMM);

    amode_agen #(.W(DW)) u_agen (
        .base(c_q.o1), .idx(c_q.x), .idx_en(c_q.md == AM_XIMM),
        .ptr(c_q.ptr), .tgt(tgt), .ptr_nxt(ptr_nxt)
    );

    amode_alu #(.W(DW)) u_alu (
        .lhs(mem_rdata), .rhs(c_q.o2), .sum(sum), .cout(add_c), .zf(add_z)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.ill   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_reg   = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (c_q.st)
            S_IDLE: begin
                if (a_we) c_d.a = a_wdata;
                if (x_we) c_d.x = x_wdata;
                if (start) begin
                    c_d.op = op;
                    c_d.md = mode;
                    c_d.sp = reg_space;
                    c_d.o1 = opnd1;
                    c_d.o2 = opnd2;
                    if (!pair_ok(op, mode, reg_space))
                        c_d.st = S_ILL;
                    else if (op == OP_MOV && (mode == AM_DIMM || mode == AM_XIMM))
                        c_d.st = S_LAST;
                    else
                        c_d.st = S_RDA;
                end
            end
            S_RDA: begin
                mem_req  = 1'b1;
                mem_reg  = imm_md ? c_q.sp : 1'b0;
                mem_addr = imm_md ? tgt : (c_q.md == AM_DD ? c_q.o2 : c_q.o1);
                c_d.st   = S_MID;
            end
            S_MID: begin
                mem_req = 1'b1;
                if (imm_md) begin
                    mem_we    = 1'b1;
                    mem_reg   = c_q.sp;
                    mem_addr  = tgt;
                    mem_wdata = sum;
                    c_d.cf    = add_c;
                    c_d.zf    = add_z;
                    c_d.done  = 1'b1;
                    c_d.st    = S_IDLE;
                end else if (c_q.md == AM_DD) begin
                    mem_we    = 1'b1;
                    mem_addr  = c_q.o1;
                    mem_wdata = mem_rdata;
                    c_d.done  = 1'b1;
                    c_d.st    = S_IDLE;
                end else begin
                    c_d.ptr   = mem_rdata;
                    mem_we    = (c_q.md == AM_IST);
                    mem_addr  = mem_rdata;
                    mem_wdata = c_q.a;
                    c_d.st    = S_LAST;
                end
            end
            S_LAST: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                c_d.done = 1'b1;
                c_d.st   = S_IDLE;
                if (imm_md) begin
                    mem_reg   = c_q.sp;
                    mem_addr  = tgt;
                    mem_wdata = c_q.o2;
                end else begin
                    if (c_q.md == AM_ILD) c_d.a = mem_rdata;
                    mem_addr  = c_q.o1;
                    mem_wdata = ptr_nxt;
                end
            end
            S_ILL: begin
                c_d.done = 1'b1;
                c_d.ill  = 1'b1;
                c_d.st   = S_IDLE;
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= S_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy    = (c_q.st != S_IDLE);
    assign done    = c_q.done;
    assign illegal = c_q.ill;
    assign acc     = c_q.a;
    assign xreg    = c_q.x;
    assign carry   = c_q.cf;
    assign zero    = c_q.zf;

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> !$past(mem_req));

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && c_q.op != OP_ADD) |=> $stable({carry, zero}));

    // R11
    busy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({c_q.op, c_q.md, c_q.sp, c_q.o1, c_q.o2}));

    // R6
    dd_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && c_q.md == AM_DD && mem_req) |-> !mem_reg);

    // R3
    rmw_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == S_MID && imm_md) |-> (mem_we && mem_addr == $past(mem_addr)));
endmodule

// File: tb/tb_amode_exec.sv
module tb_amode_exec;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = '0;
    logic [2:0] mode = '0;
    logic       reg_space = 1'b0;
    logic [7:0] opnd1 = '0, opnd2 = '0;
    logic       a_we = 1'b0, x_we = 1'b0;
    logic [7:0] a_wdata = '0, x_wdata = '0;
    logic [7:0] mem_rdata = '0;
    logic       mem_req, mem_we, mem_reg, busy, done, illegal, carry, zero;
    logic [7:0] mem_addr, mem_wdata, acc, xreg;

    logic [7:0] ram [256];
    logic [7:0] rsp [256];
    int n_chk = 0, n_bad = 0, n_req = 0, n_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amode_exec dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode),
        .reg_space(reg_space), .opnd1(opnd1), .opnd2(opnd2),
        .a_we(a_we), .a_wdata(a_wdata), .x_we(x_we), .x_wdata(x_wdata),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_reg(mem_reg), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .illegal(illegal), .acc(acc), .xreg(xreg),
        .carry(carry), .zero(zero)
    );

    always @(posedge clk) begin
        if (done) n_done++;
        if (mem_req) begin
            n_req++;
            if (mem_we) begin
                if (mem_reg) rsp[mem_addr] <= mem_wdata;
                else         ram[mem_addr] <= mem_wdata;
            end else begin
                mem_rdata <= mem_reg ? rsp[mem_addr] : ram[mem_addr];
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_a(input logic [7:0] v);
        @(negedge clk); a_we = 1'b1; a_wdata = v;
        @(negedge clk); a_we = 1'b0;
    endtask

    task automatic set_x(input logic [7:0] v);
        @(negedge clk); x_we = 1'b1; x_wdata = v;
        @(negedge clk); x_we = 1'b0;
    endtask

    // issue one instruction, return cycles to done, illegal flag, requests made
    task automatic run_op(input logic [1:0] o, input logic [2:0] m, input logic s,
                          input logic [7:0] b1, input logic [7:0] b2,
                          output int lat, output logic ill, output int reqs);
        @(negedge clk);
        op = o; mode = m; reg_space = s; opnd1 = b1; opnd2 = b2; start = 1'b1;
        n_req = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        ill  = illegal;
        reqs = n_req;
        @(negedge clk);
        chk("R12 done single cycle", {15'd0, done}, 16'd0);
        chk("R12 illegal only with done", {15'd0, illegal}, 16'd0);
    endtask

    task automatic t_reset();
        chk("R1 acc", {8'd0, acc}, 16'd0);
        chk("R1 xreg", {8'd0, xreg}, 16'd0);
        chk("R1 flags", {14'd0, carry, zero}, 16'd0);
        chk("R1 busy/done/illegal/req", {12'd0, busy, done, illegal, mem_req}, 16'd0);
    endtask

    task automatic t_load();
        set_a(8'h5A); set_x(8'h10);
        chk("R13 acc load", {8'd0, acc}, 16'h005A);
        chk("R13 x load", {8'd0, xreg}, 16'h0010);
    endtask

    task automatic t_mov_imm();
        int lat, rq; logic il;
        ram[8'h20] = 8'h00;
        run_op(2'd0, 3'd0, 1'b0, 8'h20, 8'h77, lat, il, rq);
        chk("R2 direct ram", {8'd0, ram[8'h20]}, 16'h0077);
        chk("R2 latency", lat[15:0], 16'd2);
        chk("R2 one write", rq[15:0], 16'd1);
        ram[8'h18] = 8'hAB; rsp[8'h18] = 8'h00;
        run_op(2'd0, 3'd1, 1'b1, 8'h08, 8'h66, lat, il, rq);
        chk("R2 indexed regspace", {8'd0, rsp[8'h18]}, 16'h0066);
        chk("R2 ram untouched", {8'd0, ram[8'h18]}, 16'h00AB);
    endtask

    task automatic t_add();
        int lat, rq; logic il;
        ram[8'h30] = 8'hF0;
        run_op(2'd1, 3'd0, 1'b0, 8'h30, 8'h20, lat, il, rq);
        chk("R3 add sum", {8'd0, ram[8'h30]}, 16'h0010);
        chk("R3 latency", lat[15:0], 16'd3);
        chk("R4 carry set, zero clear", {14'd0, carry, zero}, 16'b10);
        run_op(2'd1, 3'd1, 1'b0, 8'h20, 8'hF0, lat, il, rq);
        chk("R3 indexed add", {8'd0, ram[8'h30]}, 16'h0000);
        chk("R4 carry and zero", {14'd0, carry, zero}, 16'b11);
        rsp[8'h05] = 8'h40;
        run_op(2'd1, 3'd0, 1'b1, 8'h05, 8'h01, lat, il, rq);
        chk("R3 regspace add", {8'd0, rsp[8'h05]}, 16'h0041);
        chk("R4 flags clear", {14'd0, carry, zero}, 16'b00);
    endtask

    task automatic t_flags_hold();
        int lat, rq; logic il;
        ram[8'h31] = 8'hFF;
        run_op(2'd1, 3'd0, 1'b0, 8'h31, 8'h01, lat, il, rq);
        run_op(2'd0, 3'd0, 1'b0, 8'h32, 8'h05, lat, il, rq);
        chk("R5 MOV keeps flags", {14'd0, carry, zero}, 16'b11);
        ram[8'h33] = 8'h34; ram[8'h34] = 8'h09;
        run_op(2'd2, 3'd3, 1'b0, 8'h33, 8'h00, lat, il, rq);
        chk("R5 MVI keeps flags", {14'd0, carry, zero}, 16'b11);
    endtask

    task automatic t_dd();
        int lat, rq; logic il;
        ram[8'h41] = 8'hC3; ram[8'h40] = 8'h00;
        run_op(2'd0, 3'd2, 1'b0, 8'h40, 8'h41, lat, il, rq);
        chk("R6 copy", {8'd0, ram[8'h40]}, 16'h00C3);
        chk("R6 latency", lat[15:0], 16'd3);
    endtask

    task automatic t_mvi();
        int lat, rq; logic il;
        ram[8'h50] = 8'h60; ram[8'h60] = 8'h9E;
        run_op(2'd2, 3'd3, 1'b0, 8'h50, 8'h00, lat, il, rq);
        chk("R7 acc loaded", {8'd0, acc}, 16'h009E);
        chk("R7 pointer bumped", {8'd0, ram[8'h50]}, 16'h0061);
        chk("R7 latency", lat[15:0], 16'd4);
        set_a(8'h3C);
        ram[8'h52] = 8'hFF; ram[8'hFF] = 8'h00;
        run_op(2'd2, 3'd4, 1'b0, 8'h52, 8'h00, lat, il, rq);
        chk("R8 stored through pointer", {8'd0, ram[8'hFF]}, 16'h003C);
        chk("R10 pointer wraps", {8'd0, ram[8'h52]}, 16'h0000);
        chk("R8 latency", lat[15:0], 16'd4);
    endtask

    task automatic t_wrap();
        int lat, rq; logic il;
        set_x(8'hF0);
        ram[8'h10] = 8'h00;
        run_op(2'd0, 3'd1, 1'b0, 8'h20, 8'h5D, lat, il, rq);
        chk("R10 index wraps", {8'd0, ram[8'h10]}, 16'h005D);
    endtask

    task automatic t_illegal();
        logic [1:0] ops [6] = '{2'd2, 2'd0, 2'd1, 2'd0, 2'd3, 2'd0};
        logic [2:0] mds [6] = '{3'd0, 3'd3, 3'd2, 3'd2, 3'd0, 3'd5};
        logic       sps [6] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
        for (int i = 0; i < 6; i++) begin
            int lat, rq; logic il;
            ram[8'h70] = 8'hAA; rsp[8'h70] = 8'hAA; ram[8'hAA] = 8'h55;
            run_op(ops[i], mds[i], sps[i], 8'h70, 8'h70, lat, il, rq);
            chk("R9 illegal flag", {15'd0, il}, 16'd1);
            chk("R9 latency", lat[15:0], 16'd2);
            chk("R9 no memory requests", rq[15:0], 16'd0);
            chk("R9 memory untouched", {ram[8'h70], rsp[8'h70]}, 16'hAAAA);
        end
    endtask

    task automatic t_busy();
        int d0;
        ram[8'h58] = 8'h68; ram[8'h68] = 8'h21; ram[8'h7A] = 8'h00;
        @(negedge clk);
        op = 2'd2; mode = 3'd3; reg_space = 1'b0; opnd1 = 8'h58; start = 1'b1;
        d0 = n_done;
        @(negedge clk);
        chk("R11 busy after start", {15'd0, busy}, 16'd1);
        op = 2'd0; mode = 3'd0; opnd1 = 8'h7A; opnd2 = 8'h11;
        a_we = 1'b1; a_wdata = 8'hEE; x_we = 1'b1; x_wdata = 8'h99;
        @(negedge clk);
        start = 1'b0; a_we = 1'b0; x_we = 1'b0;
        repeat (8) @(negedge clk);
        chk("R11 second start ignored", {8'd0, ram[8'h7A]}, 16'h0000);
        chk("R11 only one done", 16'(n_done - d0), 16'd1);
        chk("R13 acc load ignored while busy", {8'd0, acc}, 16'h0021);
        chk("R13 x load ignored while busy", {8'd0, xreg}, 16'h00F0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; rsp[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_mov_imm();
        t_add();
        t_flags_hold();
        t_dd();
        t_mvi();
        t_wrap();
        t_illegal();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule